// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Access Permissions

This block holds a small set of recently used virtual-to-physical page mappings and answers a lookup in the same cycle it is presented. The virtual page number of the request is compared against the tag of every resident entry at once. On a match the block returns the physical address, which is the stored physical page number joined to the untouched page offset. It also applies a protection check: the access kind (load or store) and the privilege level (user or kernel) are tested against the entry's permission bits. A check that fails yields a fault in place of a translation.

When no entry matches, the block raises a miss. The surrounding walker is expected to fetch the mapping and install it through the fill port. Fills are placed in first-in first-out order, so the oldest install is overwritten once every slot is used. A permitted store marks its entry dirty, and the dirty flag is reported on each hit. A flush input empties the whole buffer in one cycle.

Top module: `tlb_assoc`

## Requirements
- R1: After reset no entry is valid, so every lookup misses until a fill occurs.
- R2: When `req_valid` is high and a valid entry's tag equals `req_vaddr[31:12]`, `lk_hit` is 1 in that same cycle. If there is no fault, `lk_paddr` is `{ppn, req_vaddr[11:0]}`.
- R3: When `req_valid` is high and no valid entry matches, `lk_miss` is 1, `lk_hit` and `lk_fault` are 0, and `lk_paddr` is 0.
- R4: Each fill writes the slot named by a pointer that starts at 0 and advances by one per fill, wrapping after `ENTRIES-1`. With all 64 slots in use, the next fill replaces the oldest install.
- R5: `flush` invalidates every entry and returns the fill pointer to 0 at the next edge. It takes priority over a fill presented in the same cycle.
- R6: A hit faults when a load finds the read bit clear, when a store finds the write bit clear, or when `req_user` is 1 and the user bit is clear. Kernel requests (`req_user`=0) ignore the user bit.
- R7: `lk_dirty` shows the dirty flag of the hit entry. A store that hits without fault sets that flag from the next cycle on. A faulting store leaves it unchanged, and a fill installs the entry with the flag clear.
- R8: With `req_valid` low, `lk_hit`, `lk_miss` and `lk_fault` are all 0, whatever the address.
- R9: While `lk_fault` is 1, `lk_paddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_vaddr | input | 32 | Virtual address (page number in 31:12, offset in 11:0) |
| req_store | input | 1 | 1 = store, 0 = load |
| req_user | input | 1 | 1 = user privilege, 0 = kernel |
| fill_valid | input | 1 | Install a mapping this cycle |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_ppn | input | 20 | Physical page number to install |
| fill_rd | input | 1 | Read permission of the new entry |
| fill_wr | input | 1 | Write permission of the new entry |
| fill_usr | input | 1 | User-accessible flag of the new entry |
| flush | input | 1 | Invalidate all entries and reset the fill pointer |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_miss | output | 1 | Lookup found no entry; refill wanted |
| lk_fault | output | 1 | Hit denied by the protection check |
| lk_paddr | output | 32 | Translated physical address, 0 on miss or fault |
| lk_dirty | output | 1 | Dirty flag of the matched entry |

## Verification
The assertions rely on the walker never installing a page number that is already resident. That rule is what keeps the match vector one-hot or empty. They also rely on a fill and a dirty-setting store not landing on the same slot in the same cycle. The stimulus meets the first rule by giving every page number a distinct value from an arithmetic formula. It meets the second by never issuing a lookup and a fill together. It then sweeps every slot across all combinations of access kind and privilege against the permission pattern derived from the slot number.

// File: rtl/tlb_assoc.sv
module tlb_assoc #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int OFF_W   = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [VPN_W+OFF_W-1:0]   req_vaddr,
  input  logic                     req_store,
  input  logic                     req_user,
  input  logic                     fill_valid,
  input  logic [VPN_W-1:0]         fill_vpn,
  input  logic [PPN_W-1:0]         fill_ppn,
  input  logic                     fill_rd,
  input  logic                     fill_wr,
  input  logic                     fill_usr,
  input  logic                     flush,
  output logic                     lk_hit,
  output logic                     lk_miss,
  output logic                     lk_fault,
  output logic [PPN_W+OFF_W-1:0]   lk_paddr,
  output logic                     lk_dirty
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] valid_q, rd_q, wr_q, us_q, dy_q, match;
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [IDX_W-1:0]   ptr_q;

  wire [VPN_W-1:0] vpn = req_vaddr[VPN_W+OFF_W-1:OFF_W];
  wire [OFF_W-1:0] off = req_vaddr[OFF_W-1:0];

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match[g] = valid_q[g] && (tag_q[g] == vpn);
    end
  endgenerate

  logic [PPN_W-1:0] sel_ppn;
  logic sel_rd, sel_wr, sel_us, sel_dy;
  always_comb begin
    sel_ppn = '0;
    sel_rd = 1'b0; sel_wr = 1'b0; sel_us = 1'b0; sel_dy = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        sel_ppn = sel_ppn | ppn_q[i];
        sel_rd  = sel_rd | rd_q[i];
        sel_wr  = sel_wr | wr_q[i];
        sel_us  = sel_us | us_q[i];
        sel_dy  = sel_dy | dy_q[i];
      end
    end
  end

  wire any_match = |match;
  wire denied = (req_store ? !sel_wr : !sel_rd) || (req_user && !sel_us);
  assign lk_hit   = req_valid && any_match;
  assign lk_miss  = req_valid && !any_match;
  assign lk_fault = lk_hit && denied;
  assign lk_paddr = (lk_hit && !denied) ? {sel_ppn, off} : '0;
  assign lk_dirty = lk_hit && sel_dy;

  wire set_dirty = lk_hit && !denied && req_store;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dy_q    <= '0;
      ptr_q   <= '0;
    end else if (flush) begin
      valid_q <= '0;
      ptr_q   <= '0;
    end else begin
      if (set_dirty) dy_q <= dy_q | match;
      if (fill_valid) begin
        valid_q[ptr_q] <= 1'b1;
        dy_q[ptr_q]    <= 1'b0;
        ptr_q          <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_valid && !flush) begin
      tag_q[ptr_q] <= fill_vpn;
      ppn_q[ptr_q] <= fill_ppn;
      rd_q[ptr_q]  <= fill_rd;
      wr_q[ptr_q]  <= fill_wr;
      us_q[ptr_q]  <= fill_usr;
    end
  end

  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(match)); // R2
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) flush |=> (valid_q == '0 && ptr_q == '0)); // R5
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n) (fill_valid && !flush) |=> ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1)); // R4
  AST_FILL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) (fill_valid && !flush) |=> (valid_q[$past(ptr_q)] && !dy_q[$past(ptr_q)])); // R7
  AST_FAULT_KEEPS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n) (lk_fault && !fill_valid && !flush) |=> $stable(dy_q)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |-> !(lk_hit || lk_miss || lk_fault)); // R8
  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n) lk_fault |-> lk_paddr == '0); // R9
endmodule

// File: tb/tlb_assoc_test.sv
`timescale 1ns/1ps
module tlb_assoc_test;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_store = 0, req_user = 0;
  logic [31:0] req_vaddr = '0;
  logic fill_valid = 0, fill_rd = 0, fill_wr = 0, fill_usr = 0, flush = 0;
  logic [19:0] fill_vpn = '0, fill_ppn = '0;
  logic lk_hit, lk_miss, lk_fault, lk_dirty;
  logic [31:0] lk_paddr;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  tlb_assoc uut (.clk, .rst_n, .req_valid, .req_vaddr, .req_store, .req_user,
    .fill_valid, .fill_vpn, .fill_ppn, .fill_rd, .fill_wr, .fill_usr, .flush,
    .lk_hit, .lk_miss, .lk_fault, .lk_paddr, .lk_dirty);

  function automatic logic [19:0] vpn_of(int k); return 20'(k * 1031 + 7); endfunction
  function automatic logic [19:0] ppn_of(int k); return 20'(k * 37 + 5); endfunction

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic fill(int k, logic r, logic w, logic u);
    @(negedge clk);
    fill_valid = 1; fill_vpn = vpn_of(k); fill_ppn = ppn_of(k);
    fill_rd = r; fill_wr = w; fill_usr = u;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic look(string r, logic [19:0] vpn, logic [11:0] off, logic st, logic usr,
                      logic ehit, logic efault, logic [19:0] eppn, logic edirty);
    @(negedge clk);
    req_valid = 1; req_vaddr = {vpn, off}; req_store = st; req_user = usr;
    #1;
    chk(r, {lk_hit, lk_miss, lk_fault}, {ehit, !ehit, efault});
    chk(r, lk_paddr, (ehit && !efault) ? {eppn, off} : 32'h0);
    if (ehit) chk(r, lk_dirty, edirty);
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R8 idle after reset", {lk_hit, lk_miss, lk_fault}, 3'b000);
    look("R1 empty after reset", vpn_of(0), 12'h0, 0, 0, 0, 0, 0, 0);

    for (int k = 0; k < 64; k++) fill(k, k[0], k[1], k[2]);

    for (int k = 0; k < 64; k++) begin
      logic r, w, u;
      logic [11:0] off;
      r = k[0]; w = k[1]; u = k[2]; off = 12'(k * 13);
      look("R2 R6 kernel load", vpn_of(k), off, 0, 0, 1, !r, ppn_of(k), 0);
      look("R6 user store", vpn_of(k), off, 1, 1, 1, !(w && u), ppn_of(k), 0);
      look("R7 dirty after user store", vpn_of(k), off, 0, 0, 1, !r, ppn_of(k), w && u);
      look("R6 kernel store", vpn_of(k), off, 1, 0, 1, !w, ppn_of(k), w && u);
      look("R7 dirty after kernel store", vpn_of(k), off, 0, 1, 1, !(r && u), ppn_of(k), w);
      look("R3 miss", vpn_of(k) + 20'd1, off, 0, 0, 0, 0, 0, 0);
    end

    @(negedge clk);
    req_valid = 0; req_vaddr = {vpn_of(3), 12'h0};
    #1;
    chk("R8 quiet without request", {lk_hit, lk_miss, lk_fault}, 3'b000);

    fill(100, 1, 1, 1);
    look("R4 oldest evicted", vpn_of(0), 12'h1, 0, 0, 0, 0, 0, 0);
    look("R4 new entry hits", vpn_of(100), 12'h2, 0, 0, 1, 0, ppn_of(100), 0);
    look("R4 second oldest kept", vpn_of(1), 12'h3, 0, 0, 1, 0, ppn_of(1), 0);

    @(negedge clk);
    flush = 1; fill_valid = 1; fill_vpn = vpn_of(200); fill_ppn = ppn_of(200);
    fill_rd = 1; fill_wr = 1; fill_usr = 1;
    @(negedge clk);
    flush = 0; fill_valid = 0;
    look("R5 fill lost to flush", vpn_of(200), 12'h0, 0, 0, 0, 0, 0, 0);
    look("R5 flushed entry", vpn_of(5), 12'h0, 0, 0, 0, 0, 0, 0);
    look("R5 flushed refill", vpn_of(100), 12'h0, 0, 0, 0, 0, 0, 0);

    for (int k = 0; k < 64; k++) fill(300 + k, 1, 0, 1);
    for (int k = 0; k < 64; k++)
      look("R5 R4 pointer restarted", vpn_of(300 + k), 12'(k), 0, 1, 1, 0, ppn_of(300 + k), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule